// File: doc/BRIEF.md
# Accumulator Bit-Gather Permute Unit

This unit holds a wide accumulator made of three registers: an 8-bit extension on top, then a high word and a low word. On each strobed operation it moves the whole accumulator six places toward its most significant end. It then writes six freshly gathered bits into the vacated bottom positions of the low word. Each gathered bit is a copy of one bit of a 32-bit source operand. A second 32-bit operand packs six 5-bit selector fields, and each field names the source position for one output bit.

Each step places six arbitrarily chosen source bits, so software can build any bit permutation of a word by issuing six steps. After those steps the permuted word sits in the low accumulator word. A load port presets all three registers in one cycle. Every update completes in a single clock.

Top module: `pperm_unit`

## Requirements
- R1: While reset is asserted, and after it is released, all three accumulator outputs read zero until the first load or operation.
- R2: On an operation, the new extension equals {old extension bits 1:0, old high bits 31:26}. The top six bits of the old extension are discarded.
- R3: On an operation, the new high word equals {old high bits 25:0, old low bits 31:26}.
- R4: On an operation, the new low bits 31:6 equal the old low bits 25:0.
- R5: On an operation, new low bit i (i = 0..5) equals the source bit at the position held in selector field i. Field i is bits 5i+4 down to 5i of the selector operand. A field value v names source bit v, counted from the least significant end (0..31).
- R6: Bits 31:30 of the selector operand have no effect on the result.
- R7: When the load strobe is high, the three registers take the load values on the next edge. The load strobe takes priority over a simultaneous operation strobe.
- R8: With neither strobe high, the accumulator holds its value.
- R9: Six operations whose selectors together name all source bits in a chosen order leave that permutation of the source in the low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Perform one shift-and-gather step |
| src_word | input | 32 | Source operand whose bits are gathered |
| sel_word | input | 32 | Six packed 5-bit selector fields |
| load_en | input | 1 | Preset the accumulator from the load inputs |
| load_ext | input | 8 | Load value for the extension |
| load_hi | input | 32 | Load value for the high word |
| load_lo | input | 32 | Load value for the low word |
| acc_ext | output | 8 | Accumulator extension register |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |

## Verification
The bench builds the unit with its default sizes: a 32-bit word, six 5-bit selectors per step, and an 8-bit extension. At these sizes every selector value is small enough to sweep in every field position. A one-hot source then shows that each field picks exactly its named bit and nothing else. Pseudo-random operands with nonzero extension and high contents exercise the chain carries across the register boundaries, including the bits dropped off the top. Two full six-step permutations confirm that a whole word can be rearranged.

// File: rtl/pperm_pkg.sv
package pperm_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_STEP = 2'd2
  } upd_kind_e;

  // Load wins over a step issued in the same cycle.
  function automatic upd_kind_e pick_update(input logic load, input logic step);
    if (load)      return UPD_LOAD;
    else if (step) return UPD_STEP;
    else           return UPD_HOLD;
  endfunction

endpackage

// File: rtl/pperm_rst_sync.sv
module pperm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/pperm_gather.sv
module pperm_gather #(
  parameter int DATA_W = 32,
  parameter int NSEL   = 6,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int USED_W = NSEL * SEL_W
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] sel,
  output logic [NSEL-1:0]   picked
);

  for (genvar g = 0; g < NSEL; g++) begin : g_pick
    logic [SEL_W-1:0] idx;
    assign idx       = sel[g*SEL_W +: SEL_W];
    assign picked[g] = src[idx];
  end

  if (USED_W < DATA_W) begin : g_spare
    logic unused_sel_hi;
    assign unused_sel_hi = ^sel[DATA_W-1:USED_W];
  end

endmodule

// File: rtl/pperm_shift.sv
module pperm_shift #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 8,
  parameter int NSEL   = 6,
  localparam int ACC_W = EXT_W + 2 * DATA_W
) (
  input  logic [EXT_W-1:0]  cur_ext,
  input  logic [DATA_W-1:0] cur_hi,
  input  logic [DATA_W-1:0] cur_lo,
  input  logic [NSEL-1:0]   fill,
  output logic [EXT_W-1:0]  nxt_ext,
  output logic [DATA_W-1:0] nxt_hi,
  output logic [DATA_W-1:0] nxt_lo
);

  logic [ACC_W-1:0] chain;
  logic [ACC_W-1:0] moved;

  always_comb begin
    chain = {cur_ext, cur_hi, cur_lo};
    moved = {chain[ACC_W-NSEL-1:0], fill};
    nxt_ext = moved[ACC_W-1 -: EXT_W];
    nxt_hi  = moved[2*DATA_W-1 -: DATA_W];
    nxt_lo  = moved[DATA_W-1:0];
  end

endmodule

// File: rtl/pperm_unit.sv
module pperm_unit #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 8,
  parameter int NSEL   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] sel_word,
  input  logic              load_en,
  input  logic [EXT_W-1:0]  load_ext,
  input  logic [DATA_W-1:0] load_hi,
  input  logic [DATA_W-1:0] load_lo,
  output logic [EXT_W-1:0]  acc_ext,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);
  import pperm_pkg::*;

  localparam int SEL_W = $clog2(DATA_W);

  initial begin
    if (NSEL * SEL_W > DATA_W) $error("selector fields do not fit the operand");
  end

  logic rst_core_n;
  logic [NSEL-1:0]   fill;
  logic [EXT_W-1:0]  step_ext, ext_d, ext_q;
  logic [DATA_W-1:0] step_hi, hi_d, hi_q;
  logic [DATA_W-1:0] step_lo, lo_d, lo_q;
  logic              acc_ce;
  upd_kind_e         kind;

  pperm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  pperm_gather #(.DATA_W(DATA_W), .NSEL(NSEL)) u_gather (
    .src(src_word), .sel(sel_word), .picked(fill)
  );

  pperm_shift #(.DATA_W(DATA_W), .EXT_W(EXT_W), .NSEL(NSEL)) u_shift (
    .cur_ext(ext_q), .cur_hi(hi_q), .cur_lo(lo_q), .fill(fill),
    .nxt_ext(step_ext), .nxt_hi(step_hi), .nxt_lo(step_lo)
  );

  // next-state
  always_comb begin
    kind   = pick_update(load_en, op_valid);
    acc_ce = (kind != UPD_HOLD);
    ext_d  = ext_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    case (kind)
      UPD_LOAD: begin
        ext_d = load_ext;
        hi_d  = load_hi;
        lo_d  = load_lo;
      end
      UPD_STEP: begin
        ext_d = step_ext;
        hi_d  = step_hi;
        lo_d  = step_lo;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ext_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (acc_ce) begin
      ext_q <= ext_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign acc_ext = ext_q;
  assign acc_hi  = hi_q;
  assign acc_lo  = lo_q;

endmodule

// File: rtl/pperm_unit_chk.sv
module pperm_unit_chk #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 8,
  parameter int NSEL   = 6,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              op_valid,
  input logic [DATA_W-1:0] src_word,
  input logic [DATA_W-1:0] sel_word,
  input logic              load_en,
  input logic [EXT_W-1:0]  load_ext,
  input logic [DATA_W-1:0] load_hi,
  input logic [DATA_W-1:0] load_lo,
  input logic [EXT_W-1:0]  acc_ext,
  input logic [DATA_W-1:0] acc_hi,
  input logic [DATA_W-1:0] acc_lo
);

  always_comb begin
    if (!rst_core_n) begin
      a_reset_zero_r1: assert (acc_ext == '0 && acc_hi == '0 && acc_lo == '0)
        else $error("accumulator not cleared in reset");
    end
  end

  p_ext_chain_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && !load_en) |=>
      acc_ext == {$past(acc_ext[EXT_W-NSEL-1:0]), $past(acc_hi[DATA_W-1 -: NSEL])});

  p_hi_chain_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && !load_en) |=>
      acc_hi == {$past(acc_hi[DATA_W-NSEL-1:0]), $past(acc_lo[DATA_W-1 -: NSEL])});

  p_lo_shift_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && !load_en) |=>
      acc_lo[DATA_W-1:NSEL] == $past(acc_lo[DATA_W-NSEL-1:0]));

  for (genvar g = 0; g < NSEL; g++) begin : g_bit
    p_gather_bit_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
      (op_valid && !load_en) |=>
        acc_lo[g] == $past(src_word[sel_word[g*SEL_W +: SEL_W]]));
  end

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_en |=> (acc_ext == $past(load_ext) && acc_hi == $past(load_hi)
                 && acc_lo == $past(load_lo)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_en && !op_valid) |=> ($stable(acc_ext) && $stable(acc_hi) && $stable(acc_lo)));

endmodule

bind pperm_unit pperm_unit_chk #(.DATA_W(DATA_W), .EXT_W(EXT_W), .NSEL(NSEL)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .op_valid(op_valid),
  .src_word(src_word), .sel_word(sel_word), .load_en(load_en),
  .load_ext(load_ext), .load_hi(load_hi), .load_lo(load_lo),
  .acc_ext(acc_ext), .acc_hi(acc_hi), .acc_lo(acc_lo)
);

// File: tb/pperm_unit_tb.sv
module pperm_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [31:0] src_word;
  logic [31:0] sel_word;
  logic        load_en;
  logic [7:0]  load_ext;
  logic [31:0] load_hi;
  logic [31:0] load_lo;
  logic [7:0]  acc_ext;
  logic [31:0] acc_hi;
  logic [31:0] acc_lo;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  m_ext;
  logic [31:0] m_hi;
  logic [31:0] m_lo;
  logic [31:0] lfsr;

  pperm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_word(src_word),
    .sel_word(sel_word), .load_en(load_en), .load_ext(load_ext),
    .load_hi(load_hi), .load_lo(load_lo), .acc_ext(acc_ext),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Expected step computed from the requirements.
  task automatic model_step(input logic [31:0] s, input logic [31:0] sel);
    logic [5:0] nb;
    for (int i = 0; i < 6; i++) nb[i] = s[sel[5*i +: 5]];
    m_ext = {m_ext[1:0], m_hi[31:26]};
    m_hi  = {m_hi[25:0], m_lo[31:26]};
    m_lo  = {m_lo[25:0], nb};
  endtask

  task automatic do_op(input logic [31:0] s, input logic [31:0] sel);
    @(negedge clk);
    op_valid = 1'b1; src_word = s; sel_word = sel;
    @(negedge clk);
    op_valid = 1'b0;
    model_step(s, sel);
  endtask

  task automatic do_load(input logic [7:0] e, input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    load_en = 1'b1; load_ext = e; load_hi = h; load_lo = l;
    @(negedge clk);
    load_en = 1'b0;
    m_ext = e; m_hi = h; m_lo = l;
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; load_en = 1'b0;
    src_word = 32'hFFFF_FFFF; sel_word = '0;
    load_ext = 8'hFF; load_hi = '1; load_lo = '1;
    repeat (3) @(negedge clk);
    chk("R1 during reset", {acc_ext, acc_hi, acc_lo}, 72'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {acc_ext, acc_hi, acc_lo}, 72'h0);
    m_ext = '0; m_hi = '0; m_lo = '0;

    // R5: sweep every selector value in every field with a one-hot source
    for (int f = 0; f < 6; f++) begin
      for (int v = 0; v < 32; v++) begin
        logic [31:0] sel;
        sel = '0;
        for (int k = 0; k < 6; k++) sel[5*k +: 5] = 5'((v + 1) % 32);
        sel[5*f +: 5] = 5'(v);
        do_load(8'h00, 32'h0, 32'h0);
        do_op(32'h1 << v, sel);
        chk("R5 one-hot sweep", {40'h0, acc_lo}, {40'h0, 32'h1 << f});
      end
    end

    // R2 R3 R4 with random contents
    lfsr = 32'h1234_5677;
    for (int t = 0; t < 40; t++) begin
      logic [7:0] e; logic [31:0] h; logic [31:0] l; logic [31:0] s; logic [31:0] sel;
      lfsr = next_rand(lfsr); e = lfsr[7:0];
      lfsr = next_rand(lfsr); h = lfsr ^ 32'hA5A5_0F0F;
      lfsr = next_rand(lfsr); l = {lfsr[15:0], lfsr[31:16]};
      lfsr = next_rand(lfsr); s = lfsr;
      lfsr = next_rand(lfsr); sel = lfsr;
      do_load(e, h, l);
      chk("R7 load", {acc_ext, acc_hi, acc_lo}, {e, h, l});
      do_op(s, sel);
      chk("R2 extension chain", {64'h0, acc_ext}, {64'h0, m_ext});
      chk("R3 high chain", {40'h0, acc_hi}, {40'h0, m_hi});
      chk("R4 low shift", {40'h0, acc_lo[31:6]}, {40'h0, m_lo[31:6]});
      chk("R5 random gather", {66'h0, acc_lo[5:0]}, {66'h0, m_lo[5:0]});
    end

    // R6: top selector bits have no effect
    for (int t = 0; t < 4; t++) begin
      logic [71:0] clean;
      do_load(8'h3C, 32'hDEAD_BEEF, 32'h0BAD_F00D);
      do_op(32'hC3A5_5A3C, 32'h0A4B_3C2D);
      clean = {acc_ext, acc_hi, acc_lo};
      do_load(8'h3C, 32'hDEAD_BEEF, 32'h0BAD_F00D);
      do_op(32'hC3A5_5A3C, {2'(t), 30'h0A4B_3C2D});
      chk("R6 selector top bits", {acc_ext, acc_hi, acc_lo}, clean);
    end

    // R7: load beats a simultaneous step
    @(negedge clk);
    op_valid = 1'b1; src_word = '1; sel_word = '0;
    load_en = 1'b1; load_ext = 8'h5A; load_hi = 32'h1357_9BDF; load_lo = 32'h2468_ACE0;
    @(negedge clk);
    op_valid = 1'b0; load_en = 1'b0;
    m_ext = 8'h5A; m_hi = 32'h1357_9BDF; m_lo = 32'h2468_ACE0;
    chk("R7 load priority", {acc_ext, acc_hi, acc_lo}, {m_ext, m_hi, m_lo});

    // R8: idle cycles with busy operands hold state
    src_word = 32'hFFFF_FFFF; sel_word = 32'h1234_5678;
    repeat (5) @(negedge clk);
    chk("R8 hold", {acc_ext, acc_hi, acc_lo}, {m_ext, m_hi, m_lo});

    // R9: full permutations, result bit b = src[(b*mul+add)%32]
    for (int p = 0; p < 2; p++) begin
      logic [31:0] s; logic [31:0] want;
      int mul; int add;
      mul = (p == 0) ? 7 : 13;
      add = (p == 0) ? 3 : 20;
      s   = (p == 0) ? 32'h8F3C_1E64 : 32'h0123_4567;
      want = '0;
      for (int b = 0; b < 32; b++) want[b] = s[(b * mul + add) % 32];
      do_load(8'h00, 32'h0, 32'h0);
      for (int j = 0; j < 6; j++) begin
        logic [31:0] sel;
        sel = '0;
        for (int i = 0; i < 6; i++) begin
          int b;
          b = 6 * (5 - j) + i;
          if (b < 32) sel[5*i +: 5] = 5'((b * mul + add) % 32);
        end
        do_op(s, sel);
      end
      chk("R9 permutation", {40'h0, acc_lo}, {40'h0, want});
    end

    finish_run();
  end

endmodule